// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a stereo serial audio stream into parallel sample pairs. It watches a bit clock, a channel-select (frame) clock and a serial data line, all sampled in the system clock domain. Each rising edge of the bit clock is one bit slot. A 3-bit format code picks one of five framings:

- a word that starts right after the frame clock changes (MSB-justified);
- the same word delayed by one slot (I2S-style);
- words of 16, 20 or 24 bits that end on the last slot before the frame clock changes (LSB-justified).

Every result is handed out as a 24-bit two's complement word. The left and right words of a frame appear together, with a one-cycle valid strobe. That strobe fires when the slot after the right half has been seen.

In the right-justified framings the word's position is fixed by the end of each half, not by its start. The receiver therefore keeps a running window of the most recent bits and takes its low N bits when the frame clock changes. The forward-counting framings instead place each bit by its slot index from the half's start. Both paths share one slot counter and one channel-pairing stage.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `smp_valid` is 0 and both sample outputs are 0.
- R2: With `fmt_sel` = 2, the MSB of a 24-bit word is in the first slot after a frame clock change, and the following 23 slots carry the rest of the word. Later slots in that half are ignored.
- R3: With `fmt_sel` = 3, the MSB is in the second slot after a frame clock change, and the next 23 slots carry the rest of the word. The left channel is the half where the frame clock is low.
- R4: With `fmt_sel` = 0, 1 or 4, the word width N is 16, 20 or 24 bits respectively. The last N slots before a frame clock change carry the word, MSB first, and every earlier slot in that half is ignored.
- R5: With `fmt_sel` = 0, 1, 2 or 4, the left channel is the half where the frame clock is high.
- R6: A word narrower than 24 bits comes out in bits 23 down to 24-N, with zeros below. Its sign bit therefore lands in bit 23.
- R7: With `fmt_sel` = 0, halves of only 16 slots (32 bit clocks per frame) are decoded correctly.
- R8: For each complete frame (left half, then right half), `smp_valid` is high for exactly one system cycle, after the first slot that follows the right half. `left_smp` and `right_smp` change only in that cycle, and they present that frame's two words.
- R9: After reset, no strobe is issued until a frame clock change has been seen and a full left half and a full right half have followed it.
- R10: Serial data and the frame clock are taken only on the rising edge of the bit clock. Changes to the data line while the bit clock stays high have no effect.
- R11: Format codes 5, 6 and 7 decode the same as code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | Serial bit clock, sampled by clk |
| frame_clk | input | 1 | Channel-select clock |
| ser_data | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 3 | Framing code (0..4, 5..7 as 2) |
| left_smp | output | 24 | Left channel sample, two's complement |
| right_smp | output | 24 | Right channel sample, two's complement |
| smp_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Each framing is driven with halves that are exactly as long as the word and with halves that are padded with filler bits. Padded halves show whether a word is anchored to the correct end of its half. The 24-slot and 25-slot halves show whether the one-slot delay of code 3 is counted.

The first frame after reset carries the most negative and the most positive value of the word width. This separates correct sign placement and zero fill from a shifted or sign-extended result.

The data line is inverted during every high phase of the bit clock, which exposes any sampling outside the rising edge. A short frame clock history before the first full frame shows whether a partial half is wrongly paired into a strobe.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int SLOT_CNT_W = 7;

    typedef enum logic [2:0] {
        FMT_RJ16 = 3'd0,
        FMT_RJ20 = 3'd1,
        FMT_LJ24 = 3'd2,
        FMT_DLY24 = 3'd3,
        FMT_RJ24 = 3'd4
    } fmt_e;

    typedef struct packed {
        logic                  tick;
        logic                  capture;
        logic                  ended_left;
        logic [SLOT_CNT_W-1:0] idx;
    } slot_info_t;

    function automatic logic fmt_is_rj(input logic [2:0] f);
        return (f == FMT_RJ16) || (f == FMT_RJ20) || (f == FMT_RJ24);
    endfunction

    function automatic int fmt_width(input logic [2:0] f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ20: return 20;
            default:  return SAMPLE_W;
        endcase
    endfunction

    function automatic int fmt_msb_slot(input logic [2:0] f);
        return (f == FMT_DLY24) ? 1 : 0;
    endfunction

    function automatic logic fmt_left_level(input logic [2:0] f);
        return (f == FMT_DLY24) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/aud_rx_tick.sv
module aud_rx_tick (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    output logic tick
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bit_clk;
    end

    assign tick = bit_clk & ~bclk_q;
endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int CNT_W = SLOT_CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       frame_clk,
    input  logic [2:0] fmt_sel,
    output slot_info_t info
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             fclk_prev;
    logic             seen;
    logic             synced;
    logic [CNT_W-1:0] idx_q;
    logic             edge_now;
    logic [CNT_W-1:0] idx_now;

    always_comb begin
        edge_now = tick && seen && (frame_clk != fclk_prev);
        if (edge_now)             idx_now = '0;
        else if (idx_q == CNT_MAX) idx_now = idx_q;
        else                      idx_now = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fclk_prev <= 1'b0;
            seen      <= 1'b0;
            synced    <= 1'b0;
            idx_q     <= '0;
        end else if (tick) begin
            fclk_prev <= frame_clk;
            seen      <= 1'b1;
            idx_q     <= idx_now;
            if (edge_now) synced <= 1'b1;
        end
    end

    always_comb begin
        info.tick       = tick;
        info.capture    = edge_now && synced;
        info.ended_left = (fclk_prev == fmt_left_level(fmt_sel));
        info.idx        = idx_now;
    end
endmodule

// File: rtl/aud_rx_shifter.sv
module aud_rx_shifter
    import aud_rx_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  slot_info_t   info,
    input  logic         ser_data,
    input  logic [2:0]   fmt_sel,
    output logic [W-1:0] word
);
    logic [W-1:0] win_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_nxt;

    always_comb begin
        int pos;
        acc_nxt = (info.idx == '0) ? '0 : acc_q;
        pos     = int'(info.idx) - fmt_msb_slot(fmt_sel);
        if (pos >= 0 && pos < W) acc_nxt[W-1-pos] = ser_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            acc_q <= '0;
        end else if (info.tick) begin
            win_q <= {win_q[W-2:0], ser_data};
            acc_q <= acc_nxt;
        end
    end

    always_comb begin
        if (fmt_is_rj(fmt_sel)) word = win_q << (W - fmt_width(fmt_sel));
        else                    word = acc_q;
    end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int W     = SAMPLE_W,
    parameter int CNT_W = SLOT_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_clk,
    input  logic         frame_clk,
    input  logic         ser_data,
    input  logic [2:0]   fmt_sel,
    output logic [W-1:0] left_smp,
    output logic [W-1:0] right_smp,
    output logic         smp_valid
);
    logic         tick;
    slot_info_t   info;
    logic [W-1:0] word;
    logic [W-1:0] left_hold;
    logic         have_left;

    aud_rx_tick u_tick (
        .clk     (clk),
        .rst     (rst),
        .bit_clk (bit_clk),
        .tick    (tick)
    );

    aud_rx_framer #(.CNT_W(CNT_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .frame_clk (frame_clk),
        .fmt_sel   (fmt_sel),
        .info      (info)
    );

    aud_rx_shifter #(.W(W)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .info     (info),
        .ser_data (ser_data),
        .fmt_sel  (fmt_sel),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_smp  <= '0;
            right_smp <= '0;
            smp_valid <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (info.capture) begin
                if (info.ended_left) begin
                    left_hold <= word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_smp  <= left_hold;
                    right_smp <= word;
                    smp_valid <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         bit_clk,
    input logic [W-1:0] left_smp,
    input logic [W-1:0] right_smp,
    input logic         smp_valid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!smp_valid && left_smp == '0 && right_smp == '0));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R8
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(left_smp) && $stable(right_smp)));

    // R10
    strobe_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> ($past(bit_clk) && !$past(bit_clk, 2)));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_clk   (bit_clk),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .smp_valid (smp_valid)
);

// File: tb/aud_serial_rx_tb.sv
`timescale 1ns/1ps
module aud_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0;
    logic        frame_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [2:0]  fmt_sel = 3'd2;
    logic [23:0] left_smp;
    logic [23:0] right_smp;
    logic        smp_valid;

    int          checks = 0;
    int          errors = 0;
    int          pulses = 0;
    logic        prev_valid = 1'b0;
    bit          done = 1'b0;
    logic [47:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    aud_serial_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .bit_clk   (bit_clk),
        .frame_clk (frame_clk),
        .ser_data  (ser_data),
        .fmt_sel   (fmt_sel),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .smp_valid (smp_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every strobe against the queued expectation.
    always @(negedge clk) begin
        if (!rst) begin
            if (smp_valid) begin
                pulses++;
                check(!prev_valid, "R8", "strobe longer than one cycle", 48'd1, 48'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "strobe without a complete frame",
                          {left_smp, right_smp}, 48'd0);
                end else begin
                    logic [47:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({left_smp, right_smp} == e, t, "sample pair",
                          {left_smp, right_smp}, e);
                end
            end
            prev_valid = smp_valid;
        end else begin
            prev_valid = 1'b0;
        end
    end

    function automatic int width_of(input int f);
        if (f == 0) return 16;
        if (f == 1) return 20;
        return 24;
    endfunction

    function automatic bit is_rj(input int f);
        return (f == 0) || (f == 1) || (f == 4);
    endfunction

    function automatic bit bit_for(input int f, input int s, input int i,
                                   input logic [23:0] raw);
        int n;
        int k;
        int off;
        n = width_of(f);
        if (is_rj(f)) begin
            k = s - 1 - i;
            if (k < n) return raw[k];
            return bit'(i % 2);
        end
        off = (f == 3) ? 1 : 0;
        if (i >= off && i - off < 24) return raw[23 - (i - off)];
        return bit'(i % 2);
    endfunction

    // One bit slot: low phase, rising edge, inverted data while high (R10).
    task automatic slot(input bit lr, input bit d);
        @(negedge clk);
        bit_clk   = 1'b0;
        frame_clk = lr;
        ser_data  = d;
        @(negedge clk);
        @(negedge clk);
        bit_clk = 1'b1;
        @(negedge clk);
        ser_data = ~d;
        @(negedge clk);
    endtask

    task automatic run_fmt(input int f, input int s, input int nfr,
                           input string tag, input int seed);
        int          n;
        bit          ll;
        logic [23:0] mask;
        @(negedge clk);
        rst     = 1'b1;
        bit_clk = 1'b0;
        fmt_sel = f[2:0];
        repeat (2) @(negedge clk);
        check(!smp_valid && left_smp == 0 && right_smp == 0, "R1", "reset state",
              {left_smp, right_smp}, 48'd0);
        rst = 1'b0;
        exp_q.delete();
        tag_q.delete();
        pulses = 0;
        n    = width_of(f);
        mask = (n == 24) ? 24'hFFFFFF : ((24'd1 << n) - 24'd1);
        ll   = (f == 3) ? 1'b0 : 1'b1;
        // Partial history: no strobe may come from it (R9).
        repeat (5) slot(ll, 1'b1);
        repeat (9) slot(!ll, 1'b0);
        check(pulses == 0, "R9", "strobe before first full frame",
              48'(pulses), 48'd0);
        for (int fr = 0; fr < nfr; fr++) begin
            logic [23:0] lv;
            logic [23:0] rv;
            if (fr == 0) begin
                lv = (24'd1 << (n - 1));
                rv = (24'd1 << (n - 1)) - 24'd1;
            end else begin
                lv = 24'((seed * 32'h9E3779B1) ^ (fr * 32'h85EBCA6B)) & mask;
                rv = 24'((seed * 32'h27D4EB2F) + (fr * 32'h165667B1)) & mask;
            end
            for (int i = 0; i < s; i++) slot(ll, bit_for(f, s, i, lv));
            for (int i = 0; i < s; i++) slot(!ll, bit_for(f, s, i, rv));
            exp_q.push_back({lv << (24 - n), rv << (24 - n)});
            tag_q.push_back(tag);
        end
        slot(ll, 1'b0);
        slot(ll, 1'b0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8", "frames left undelivered",
              48'(exp_q.size()), 48'd0);
        check(pulses == nfr, "R8", "strobe count", 48'(pulses), 48'(nfr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!smp_valid && left_smp == 0 && right_smp == 0, "R1", "initial reset",
              {left_smp, right_smp}, 48'd0);
        run_fmt(2, 32, 3, "R2 R5 R10", 11);
        run_fmt(2, 24, 2, "R2 R5", 12);
        run_fmt(3, 32, 3, "R3 R10", 13);
        run_fmt(3, 25, 2, "R3", 14);
        run_fmt(0, 32, 3, "R4 R5 R6", 15);
        run_fmt(0, 16, 3, "R7 R6", 16);
        run_fmt(1, 32, 3, "R4 R6", 17);
        run_fmt(4, 32, 3, "R4 R5", 18);
        run_fmt(4, 24, 2, "R4", 19);
        run_fmt(5, 32, 2, "R11", 20);
        run_fmt(7, 28, 2, "R11", 21);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule